// File: doc/BRIEF.md
# Inertial Delay Pulse Filter

This block delays a single-bit level by N ticks of a slow time base that runs inside a faster system clock. A tick-enable strobe marks the time base. The block samples its input and updates its state only on cycles where that strobe is high.

It has two behaviours, chosen by a mode pin. In transport mode it is a plain delay line: every pulse comes out N ticks later, however short. In inertial mode it removes glitches. The output moves to the delayed level only once the input has held one level for more than N consecutive ticks. A shorter excursion is swallowed, and the output keeps whatever it held before.

N is set at run time and is limited by a depth parameter. The output is registered, so it settles one clock after the tick edge.

Top module: `inertial_filter`

## Requirements
- R1: Reset, active low and asynchronous, drives `dout` to 0. It also clears the sample history to all zeros and clears the run counter. Samples from before reset count as 0.
- R2: On cycles with `tick` low, `dout` and all internal state stay unchanged, whatever `din`, `dly` or `transport` do.
- R3: With `transport`=1, after each tick `dout` equals the `din` value sampled N ticks earlier, counting the current tick as 0 ticks earlier. Every pulse is passed.
- R4: With `transport`=0, after a tick `dout` takes the N-tick-delayed sample when the input has held its level for more than N consecutive ticks, counting the current tick. The run count restarts at reset.
- R5: With `transport`=0, a pulse lasting N ticks or fewer never reaches `dout`, and `dout` keeps its previous value.
- R6: A `dly` value greater than `MAX_DLY` acts as `MAX_DLY`.
- R7: With N=0, in either mode, `dout` equals the `din` sampled at the latest tick, one clock after that tick.
- R8: With `transport`=0 and N of 1 or more, a tick where `din` differs from the previous sample never changes `dout`.
- R9: The run counter saturates, so a level held far longer than `MAX_DLY` ticks is still followed correctly by later edges and pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base strobe; state advances only when high |
| transport | input | 1 | 1 = transport delay line, 0 = inertial filter |
| dly | input | $clog2(MAX_DLY+1) | Delay N in ticks, clamped to MAX_DLY |
| din | input | 1 | Level to be delayed |
| dout | output | 1 | Delayed, optionally filtered level |

## Verification
The assertions check four things on every cycle. The output holds on non-tick cycles. In inertial mode, any output move after a tick lands on the level just sampled. In inertial mode with N of 1 or more, an input edge never moves the output in the same tick. With N=0, the output follows the sample one clock later.

Some behaviours depend on the history and need the bench's scenarios. These include the exact N-tick lag in transport mode, the pulse-width threshold between rejection and passage, clamping of oversized delays, and correct behaviour after the run counter saturates. The bench's reference model compares all of these on every clock.

// File: rtl/inertial_filter.sv
module inertial_filter #(
  parameter int MAX_DLY = 8,
  localparam int DW = $clog2(MAX_DLY + 1),
  localparam int CW = $clog2(MAX_DLY + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          transport,
  input  logic [DW-1:0] dly,
  input  logic          din,
  output logic          dout
);
  localparam logic [CW-1:0] CNT_TOP = CW'(MAX_DLY + 1);
  localparam logic [DW-1:0] DLY_TOP = DW'(MAX_DLY);

  logic [MAX_DLY-1:0] hist;
  logic [MAX_DLY:0]   hist_sh;
  logic [CW-1:0]      cnt, cnt_nx;
  logic [DW-1:0]      n_eff;
  logic               dly_bit, stable;

  assign n_eff   = (dly > DLY_TOP) ? DLY_TOP : dly;
  assign hist_sh = {hist, din};
  assign cnt_nx  = (din != hist[0]) ? CW'(1) :
                   (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
  assign stable  = cnt_nx > CW'(n_eff);

  always_comb begin
    dly_bit = din;
    for (int k = 1; k <= MAX_DLY; k++)
      if (n_eff == DW'(k)) dly_bit = hist[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
      dout <= 1'b0;
    end else if (tick) begin
      hist <= hist_sh[MAX_DLY-1:0];
      cnt  <= cnt_nx;
      if (transport || stable) dout <= dly_bit;
    end
  end
endmodule

// File: rtl/inertial_filter_chk.sv
module inertial_filter_chk #(
  parameter int MAX_DLY = 8,
  localparam int DW = $clog2(MAX_DLY + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          transport,
  input logic [DW-1:0] dly,
  input logic          din,
  input logic          dout
);
  logic last_smp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_smp <= 1'b0;
    else if (tick) last_smp <= din;

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> dout == 1'b0);

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout));

  assert_move_to_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !transport) |=> (dout == $past(dout) || dout == $past(din)));

  assert_edge_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !transport && dly != '0 && din != last_smp) |=> $stable(dout));

  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dly == '0) |=> dout == $past(din));
endmodule

bind inertial_filter inertial_filter_chk #(.MAX_DLY(MAX_DLY)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .transport(transport),
  .dly(dly), .din(din), .dout(dout));

// File: tb/inertial_filter_tb_top.sv
module inertial_filter_tb_top;
  localparam int MAX = 8;
  localparam int DW = $clog2(MAX + 1);

  logic clk = 0, rst_n = 0, tick = 0, transport = 0, din = 0;
  logic [DW-1:0] dly = '0;
  logic dout;
  int checks = 0, errors = 0;
  bit done = 0;

  bit m_hist[$];
  int m_run;
  bit m_out;
  string tag = "R1";

  always #10 clk = ~clk;

  inertial_filter #(.MAX_DLY(MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .transport(transport),
    .dly(dly), .din(din), .dout(dout));

  task automatic model_reset();
    m_hist = {};
    for (int i = 0; i < MAX; i++) m_hist.push_back(1'b0);
    m_run = 0;
    m_out = 0;
  endtask

  task automatic check(string req);
    checks++;
    if (dout !== m_out) begin
      errors++;
      $display("FAIL %s: dout=%0b expected=%0b at %0t", req, dout, m_out, $time);
    end
  endtask

  task automatic step(bit t, bit d);
    int n;
    bit del;
    @(negedge clk);
    tick = t; din = d;
    if (t) begin
      n = (int'(dly) > MAX) ? MAX : int'(dly);
      m_run = (d != m_hist[0]) ? 1 : m_run + 1;
      del = (n == 0) ? d : m_hist[n-1];
      if (transport || m_run > n) m_out = del;
      m_hist.push_front(d);
      void'(m_hist.pop_back());
    end
    @(posedge clk); #2;
    check(tag);
  endtask

  task automatic hold(bit d, int len);
    for (int i = 0; i < len; i++) step(1, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0;
    model_reset();
    #2; tag = "R1"; check("R1");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    model_reset();
    #35; check("R1");
    @(negedge clk); rst_n = 1;
    step(0, 0); check("R1");

    // R3 transport, N=3, random pattern
    tag = "R3"; transport = 1; dly = 3;
    for (int i = 0; i < 60; i++) step(1, 1'($urandom_range(0, 1)));
    // R3 single-tick pulses still pass
    hold(0, 5); step(1, 1); hold(0, 6);

    // R2 no tick: inputs wiggle, nothing moves
    tag = "R2";
    for (int i = 0; i < 12; i++) begin
      dly = DW'(i % 9); transport = 1'(i % 2);
      step(0, 1'(i % 3 == 0));
    end
    transport = 1; dly = 3;

    // R1 mid-run reset clears history
    hold(1, 6);
    do_reset();
    tag = "R1"; transport = 1; dly = 3;
    hold(0, 3);

    // R4/R5/R8 inertial N=3, pulse widths 1..6
    transport = 0; dly = 3;
    tag = "R4"; hold(0, 6);
    for (int w = 1; w <= 6; w++) begin
      tag = (w <= 3) ? "R5" : "R4";
      hold(1, w);
      tag = "R8"; hold(0, 7);
    end
    tag = "R5";
    for (int i = 0; i < 40; i++) step(1, 1'($urandom_range(0, 1)));
    tag = "R4";
    for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 1'(i / 5 % 2));

    // R7 zero delay, both modes
    tag = "R7"; dly = 0;
    for (int m = 0; m < 2; m++) begin
      transport = 1'(m);
      for (int i = 0; i < 20; i++) step(1, 1'($urandom_range(0, 1)));
    end

    // R6 clamp oversized delay
    tag = "R6"; dly = DW'(15); transport = 1;
    for (int i = 0; i < 30; i++) step(1, 1'($urandom_range(0, 1)));
    transport = 0;
    hold(1, 8); hold(0, 9); hold(1, 10); hold(0, 4);

    // R9 long run saturates counter, then pulses
    tag = "R9"; dly = 2; transport = 0;
    hold(1, 40); hold(0, 2); hold(1, 3); hold(0, 3); hold(1, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: dout=%0b expected=finish", dout);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule